// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is a single bus-master channel that moves audio samples out of host memory. Software builds a ring of 32 descriptors in memory. Each descriptor is 8 bytes: a 32-bit word with the buffer address, then a 32-bit word holding the buffer length and two flags. Software then programs the ring base, names the last entry it has filled, and sets the run bit. The channel reads each descriptor in turn. It hands out one 32-bit sample from the described buffer each time the downstream link pulses its sample-consumed strobe, and it advances to the next descriptor when the buffer is empty.

The channel stops after it finishes the descriptor whose index matches the last-valid index that software set. To continue, software moves that index forward while the run bit stays set. Each descriptor carries two flags. One asks for a completion event when that buffer finishes. The other chooses what is sent out when the strobe finds no sample ready: a repeat of the last real sample, or silence. Three status events are kept until software clears them by writing ones: buffer completion, last-valid buffer done, and FIFO error (underrun). Each event has its own enable. The interrupt output is the OR of the enabled events.

Registers sit on a simple word-addressed bus with byte enables. Memory is reached through a read port with one cycle of latency.

Top module: `adma_chan`

## Requirements
- R1: After reset the register words read as follows: word 0 reads 0x00000000, word 1 reads 0x00030000 and word 2 reads 0x00010000. The interrupt is low.
- R2: Descriptor `i` is two words at base+8*i: first the buffer address, then the control word. Bits 15:0 of the control word give the length in samples. The k-th strobe of a buffer reads the sample at buffer address + 4*k. That sample appears on `smp_data` with `smp_vld` high in the cycle after the strobe. Every memory read is word aligned.
- R3: After each completed buffer that is not the last valid one, the current index increases by one modulo 32. The prefetched index (word 2, bits 23:16) always reads as the current index plus one, modulo 32.
- R4: Suppose the channel completes the descriptor whose index equals the last-valid index. Then it halts: status bit 0 (halted) is 1, bit 1 (current equals last valid) is 1 and bit 2 (last-valid done) is set. The current index stays where it is, and no memory read is issued while the channel is halted.
- R5: While run is set, writing a last-valid index that differs from the current index restarts a halted channel at the next descriptor.
- R6: Status bits 4:2 sit in word 1, bits 20:18, and are written through byte lane 2. Writing a 1 to one of them clears it and writing a 0 leaves it unchanged. Status bits 1:0 ignore writes.
- R7: The interrupt output is (bit3 AND ctrl bit4) OR (bit4 AND ctrl bit3) OR (bit2 AND ctrl bit2). Status bit 3 is set only when the finished descriptor has control bit 31 set.
- R8: A strobe that arrives while the channel is not streaming sets status bit 4. The word sent out for it is the last delivered sample if the current descriptor has control bit 30 set, and zero if it does not.
- R9: Writing control bit 1 (word 2, bit 25) clears base, both indices, position, run and the status events one cycle later, and leaves control bits 4:2 as they are. Control bit 1 reads back as 0 after that.
- R10: The position field (word 2, bits 15:0) is loaded with the descriptor length when the descriptor is fetched. It then counts down by one for each sample delivered.
- R11: Base address bits 2:0 always read as zero, whatever is written to them.
- R12: Register lanes are fixed. Word 1 holds current index in bits 7:0, last-valid index in bits 15:8 and status in bits 31:16. Word 2 holds position in bits 15:0, prefetched index in bits 23:16 and control in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word index |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the request |
| smp_tick | input | 1 | Sample-consumed strobe from the link |
| smp_vld | output | 1 | Outgoing sample valid |
| smp_data | output | 32 | Outgoing sample |

## Verification
The assertions assume that memory returns data exactly one cycle after every request and that software never sets the reset bit twice in a row. They also assume that the strobe is a single-cycle pulse. The bench meets these assumptions in three ways. Its memory model answers on a fixed one-cycle schedule. Every register write is followed by an idle cycle. Strobes are spaced several cycles apart, and a strobe is sent after a descriptor fetch only once the fetch has had time to finish. The only exceptions are the strobes that are meant to cause an underrun.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int D_IOC  = 31;
  localparam int D_BUP  = 30;

  typedef enum logic [2:0] {
    ST_HALT, ST_FADDR, ST_FCTL, ST_FLEN, ST_XFER
  } adma_st_e;

  typedef struct packed {
    logic fe;
    logic bc;
    logic lvb;
  } adma_evt_t;
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_word,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  civ,
  input  logic [LEN_W-1:0]  remaining,
  input  logic              halted,
  input  adma_evt_t         evt,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  lvi,
  output logic              run,
  output logic              rr_pend,
  output logic              irq
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  lvi_q, lvi_d, piv;
  logic [2:0]        stat_q, stat_d, clr;
  logic [2:0]        en_q, en_d;
  logic              run_q, run_d, rr_q, rr_d;
  logic              wr0, wr1, wr2, base_en, lvi_en;
  logic [15:0]       sr;
  logic [7:0]        cr;

  assign wr0 = reg_wr && (reg_word == 2'd0);
  assign wr1 = reg_wr && (reg_word == 2'd1);
  assign wr2 = reg_wr && (reg_word == 2'd2) && reg_be[3];
  assign base_en = wr0 || rr_q;
  assign lvi_en  = (wr1 && reg_be[1]) || rr_q;
  assign clr = (wr1 && reg_be[2]) ? reg_wdata[20:18] : 3'b000;

  always_comb begin
    base_d = base_q;
    lvi_d  = lvi_q;
    stat_d = (stat_q & ~clr) | evt;
    en_d   = en_q;
    run_d  = run_q;
    rr_d   = 1'b0;
    if (rr_q) begin
      base_d = '0;
      lvi_d  = '0;
      stat_d = '0;
      run_d  = 1'b0;
    end
    if (wr0) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) base_d[8*b +: 8] = reg_wdata[8*b +: 8];
    end
    base_d[2:0] = 3'b000;
    if (wr1 && reg_be[1]) lvi_d = reg_wdata[8 +: IDX_W];
    if (wr2) begin
      en_d  = reg_wdata[28:26];
      rr_d  = reg_wdata[25];
      run_d = reg_wdata[24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lvi_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      run_q  <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      if (lvi_en)  lvi_q  <= lvi_d;
      stat_q <= stat_d;
      en_q   <= en_d;
      run_q  <= run_d;
      rr_q   <= rr_d;
    end
  end

  assign piv = civ + 1'b1;
  assign sr  = {11'd0, stat_q, (civ == lvi_q), halted};
  assign cr  = {3'b000, en_q, rr_q, run_q};

  always_comb begin
    case (reg_word)
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = {sr, 8'(lvi_q), 8'(civ)};
      2'd2:    reg_rdata = {cr, 8'(piv), remaining};
      default: reg_rdata = '0;
    endcase
  end

  // en_q = {completion, fifo error, last valid}; stat_q = {fifo error, completion, last valid}
  assign irq = (stat_q[1] & en_q[2]) | (stat_q[2] & en_q[1]) | (stat_q[0] & en_q[0]);

  assign base    = base_q;
  assign lvi     = lvi_q;
  assign run     = run_q;
  assign rr_pend = rr_q;
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rr,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  lvi,
  input  logic              smp_tick,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              smp_vld,
  output logic [31:0]       smp_data,
  output logic [IDX_W-1:0]  civ,
  output logic [LEN_W-1:0]  remaining,
  output logic              halted,
  output adma_evt_t         evt
);
  adma_st_e          st_q, st_d;
  logic [IDX_W-1:0]  civ_q, civ_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, fetch_addr;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              done_q, done_d, ioc_q, ioc_d, bup_q, bup_d;
  logic              mem_q, mem_d, vld_q, vld_d;
  logic [31:0]       fill_q, fill_d, last_q, last_d, prev_smp;
  logic              complete, ioc_now, streaming;

  assign fetch_addr = base + ADDR_W'({civ_q, 3'b000});
  assign streaming  = (st_q == ST_XFER) && run;
  assign prev_smp   = mem_q ? mem_rdata : last_q;

  always_comb begin
    st_d = st_q; civ_d = civ_q; ptr_d = ptr_q; rem_d = rem_q;
    done_d = done_q; ioc_d = ioc_q; bup_d = bup_q;
    fill_d = fill_q; last_d = last_q;
    mem_d = 1'b0; vld_d = smp_tick;
    mem_rd = 1'b0; mem_addr = '0; evt = '0;
    complete = 1'b0; ioc_now = ioc_q;
    case (st_q)
      ST_HALT: begin
        if (run && !done_q) st_d = ST_FADDR;
        else if (run && done_q && (lvi != civ_q)) begin
          civ_d  = civ_q + 1'b1;
          done_d = 1'b0;
          st_d   = ST_FADDR;
        end
      end
      ST_FADDR: begin
        mem_rd = 1'b1; mem_addr = fetch_addr; st_d = ST_FCTL;
      end
      ST_FCTL: begin
        mem_rd = 1'b1; mem_addr = fetch_addr + 32'd4;
        ptr_d = {mem_rdata[ADDR_W-1:2], 2'b00};
        st_d = ST_FLEN;
      end
      ST_FLEN: begin
        ioc_d = mem_rdata[D_IOC]; bup_d = mem_rdata[D_BUP];
        ioc_now = mem_rdata[D_IOC];
        rem_d = mem_rdata[LEN_W-1:0];
        if (mem_rdata[LEN_W-1:0] == '0) complete = 1'b1;
        else st_d = ST_XFER;
      end
      ST_XFER: begin
        if (smp_tick && run) begin
          mem_rd = 1'b1; mem_addr = ptr_q;
          ptr_d = ptr_q + 32'd4;
          rem_d = rem_q - 1'b1;
          mem_d = 1'b1;
          if (rem_q == LEN_W'(1)) complete = 1'b1;
        end
      end
      default: st_d = ST_HALT;
    endcase
    if (complete) begin
      evt.bc = ioc_now;
      if (civ_q == lvi) begin
        st_d = ST_HALT; done_d = 1'b1; evt.lvb = 1'b1;
      end else begin
        civ_d = civ_q + 1'b1; st_d = ST_FADDR;
      end
    end
    if (mem_q) last_d = mem_rdata;
    if (smp_tick && !streaming) begin
      evt.fe = 1'b1;
      fill_d = bup_q ? prev_smp : 32'd0;
    end
    if (rr) begin
      st_d = ST_HALT; civ_d = '0; ptr_d = '0; rem_d = '0;
      done_d = 1'b0; ioc_d = 1'b0; bup_d = 1'b0;
      last_d = '0; fill_d = '0; evt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HALT; civ_q <= '0; ptr_q <= '0; rem_q <= '0;
      done_q <= 1'b0; ioc_q <= 1'b0; bup_q <= 1'b0;
      mem_q <= 1'b0; vld_q <= 1'b0; fill_q <= '0; last_q <= '0;
    end else begin
      st_q <= st_d; civ_q <= civ_d; ptr_q <= ptr_d; rem_q <= rem_d;
      done_q <= done_d; ioc_q <= ioc_d; bup_q <= bup_d;
      mem_q <= mem_d; vld_q <= vld_d; fill_q <= fill_d; last_q <= last_d;
    end
  end

  assign smp_vld   = vld_q;
  assign smp_data  = mem_q ? mem_rdata : fill_q;
  assign civ       = civ_q;
  assign remaining = rem_q;
  assign halted    = (st_q == ST_HALT);
endmodule

// File: rtl/adma_chan.sv
module adma_chan
  import adma_pkg::*;
#(
  parameter int NUM_DESC = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_word,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  input  logic        smp_tick,
  output logic        smp_vld,
  output logic [31:0] smp_data
);
  localparam int IDX_W = $clog2(NUM_DESC);

  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  lvi, civ;
  logic [LEN_W-1:0]  remaining;
  logic              run, rr_pend, halted;
  adma_evt_t         evt;

  adma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .civ(civ), .remaining(remaining), .halted(halted), .evt(evt),
    .base(base), .lvi(lvi), .run(run), .rr_pend(rr_pend), .irq(irq)
  );

  adma_engine #(.IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .rr(rr_pend), .base(base),
    .lvi(lvi), .smp_tick(smp_tick), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .smp_vld(smp_vld), .smp_data(smp_data),
    .civ(civ), .remaining(remaining), .halted(halted), .evt(evt)
  );
endmodule

// File: rtl/adma_chan_chk.sv
module adma_chan_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] civ,
  input logic             halted,
  input logic             mem_rd,
  input logic [31:0]      mem_addr,
  input logic             ev_lvb,
  input logic             rr_pend,
  input logic             smp_tick,
  input logic             smp_vld
);
  logic [IDX_W-1:0] civ_q, civ_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) civ_q <= '0;
    else        civ_q <= civ;
  end
  assign civ_inc = civ_q + 1'b1;

  // R3
  civ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (civ != civ_q) |-> ((civ == civ_inc) || (civ == '0)));

  // R4
  halt_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);

  // R4
  lvb_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lvb |=> halted);

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00));

  // R9
  rr_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_pend |=> !rr_pend);

  // R2
  vld_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> $past(smp_tick));
endmodule

bind adma_chan adma_chan_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .civ(civ), .halted(halted), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .ev_lvb(evt.lvb), .rr_pend(rr_pend),
  .smp_tick(smp_tick), .smp_vld(smp_vld)
);

// File: tb/adma_chan_bench.sv
`timescale 1ns/1ps
module adma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, mem_rd, smp_vld;
  logic [31:0] mem_addr, smp_data;
  logic [31:0] mem_rdata = 32'd0;
  logic        smp_tick = 1'b0;
  logic [31:0] mem [0:255];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adma_chan u_adma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .smp_tick(smp_tick), .smp_vld(smp_vld), .smp_data(smp_data)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = w; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    reg_word = w;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(output logic v, output logic [31:0] d);
    @(negedge clk);
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    v = smp_vld; d = smp_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 word0", d, 32'h0);
    rd(2'd1, d); chk("R1 R12 word1", d, 32'h0003_0000);
    rd(2'd2, d); chk("R1 R12 word2", d, 32'h0001_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] d; logic v;
    mem[8'h40] = 32'h200; mem[8'h41] = 32'h8000_0003;
    mem[8'h42] = 32'h240; mem[8'h43] = 32'h4000_0002;
    mem[8'h44] = 32'h280; mem[8'h45] = 32'h0000_0001;
    for (int k = 0; k < 3; k++) mem[8'h80 + k] = 32'hC0DE_0000 + k;
    for (int k = 0; k < 2; k++) mem[8'h90 + k] = 32'hBEEF_0000 + k;
    mem[8'hA0] = 32'h1234_5678;
    wr(2'd0, 4'hF, 32'h0000_0107);
    idle(1); rd(2'd0, d); chk("R11 base align", d, 32'h100);
    wr(2'd1, 4'h2, 32'h0000_0100);
    wr(2'd2, 4'h8, 32'h1100_0000);
    idle(6); rd(2'd2, d); chk("R10 R12 len loaded", d, 32'h1101_0003);
    tick(v, d); chk("R2 sample0", d, 32'hC0DE_0000); chk("R2 vld", {31'd0, v}, 32'd1);
    tick(v, d); chk("R2 sample1", d, 32'hC0DE_0001);
    rd(2'd2, d); chk("R10 countdown", {16'd0, d[15:0]}, 32'd1);
    tick(v, d); chk("R2 sample2", d, 32'hC0DE_0002);
    rd(2'd1, d); chk("R3 R7 advance and completion", d, 32'h000A_0101);
    chk("R7 irq on completion", {31'd0, irq}, 32'd1);
    wr(2'd1, 4'h4, 32'h001F_0000);
    idle(1); rd(2'd1, d); chk("R6 w1c keeps ro bits", d, 32'h0002_0101);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);
    idle(5);
    tick(v, d); chk("R2 desc1 sample0", d, 32'hBEEF_0000);
    tick(v, d); chk("R2 desc1 sample1", d, 32'hBEEF_0001);
    rd(2'd1, d); chk("R4 halt at last", d, 32'h0007_0101);
    chk("R7 masked lvb", {31'd0, irq}, 32'd0);
    idle(3); rd(2'd1, d); chk("R4 index held", d, 32'h0007_0101);
  endtask

  task automatic t_underrun;
    logic [31:0] d; logic v;
    tick(v, d); chk("R8 repeat last", d, 32'hBEEF_0001);
    rd(2'd1, d); chk("R8 fifo error set", d, 32'h0017_0101);
    wr(2'd2, 4'h8, 32'h1900_0000);
    idle(1); chk("R7 fifo irq", {31'd0, irq}, 32'd1);
    wr(2'd1, 4'h4, 32'h0010_0000);
    idle(1); rd(2'd1, d); chk("R6 zero keeps bit", d, 32'h0007_0101);
    wr(2'd1, 4'h4, 32'h0004_0000);
  endtask

  task automatic t_resume;
    logic [31:0] d; logic v;
    wr(2'd1, 4'h2, 32'h0000_0200);
    idle(6); rd(2'd1, d); chk("R5 resumed next", d, 32'h0002_0202);
    tick(v, d); chk("R5 R2 sample", d, 32'h1234_5678);
    idle(2);
    tick(v, d); chk("R8 silence", d, 32'h0);
    chk("R8 silence vld", {31'd0, v}, 32'd1);
  endtask

  task automatic t_chreset;
    logic [31:0] d;
    wr(2'd2, 4'h8, 32'h1E00_0000);
    rd(2'd2, d); chk("R9 bit pending", {24'd0, d[31:24]}, 32'h1E);
    idle(1);
    rd(2'd2, d); chk("R9 ctrl after", d, 32'h1C01_0000);
    rd(2'd1, d); chk("R9 word1 after", d, 32'h0003_0000);
    rd(2'd0, d); chk("R9 base after", d, 32'h0);
  endtask

  task automatic t_wrap;
    logic [31:0] d; logic v;
    for (int i = 0; i < 32; i++) begin
      mem[2*i] = 32'h300 + 4*i; mem[2*i+1] = 32'h1;
      mem[8'hC0 + i] = 32'hA500_0000 + i;
    end
    wr(2'd1, 4'h2, 32'h0000_1F00);
    wr(2'd2, 4'h8, 32'h1D00_0000);
    for (int i = 0; i < 32; i++) begin
      idle(6);
      tick(v, d); chk("R3 ring sample", d, 32'hA500_0000 + i);
    end
    rd(2'd1, d); chk("R3 R4 at 31", d, 32'h0007_1F1F);
    rd(2'd2, d); chk("R3 prefetch wraps", d, 32'h1D00_0000);
    chk("R7 lvb irq", {31'd0, irq}, 32'd1);
    wr(2'd1, 4'h2, 32'h0000_0000);
    idle(6); rd(2'd1, d); chk("R3 R5 index wraps", d, 32'h0006_0000);
    tick(v, d); chk("R3 wrapped sample", d, 32'hA500_0000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_basic;
    t_underrun;
    t_resume;
    t_chreset;
    t_wrap;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule